// File: doc/BRIEF.md
# Periodic Tick Alarm

This block turns the carry strobes of a calendar clock into a periodic event on one active-low line that behaves like an open-drain output. A two-bit period code picks which digit carry counts as an event: the 1/64 s digit, the seconds digit, the minutes digit or the hours digit. No period counter of its own is used. The event happens in the cycle in which the chosen digit receives its carry.

A mode select decides what an event does. In latched mode the line is pulled low and held until software clears the flag. In pulse mode the line is pulled low for a fixed 7.8125 ms and then released on its own. That width is timed as 64 periods of an 8192 Hz enable. A status flag always shows whether the line is pulled low. Software clears it with a one-cycle strobe, which stands for a write of zero to the flag. A mask input releases the line and blocks all events.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset the flag `irq_flag_o` is 0 and `line_n_o` is 1 (released).
- R2: `period_sel_i` picks the event source bit of `carry_i`: 0 selects bit 0 (1/64 s carry), 1 selects bit 1 (seconds), 2 selects bit 2 (minutes), 3 selects bit 3 (hours). Strobes on the other bits have no effect.
- R3: With `mask_i` low, a strobe on the selected carry bit sets the flag at the next clock edge.
- R4: While `mask_i` is 1, the flag is cleared at the next edge and carry strobes do not set it.
- R5: In latched mode (`latch_mode_i`=1), a set flag stays set until a clear strobe or the mask removes it.
- R6: In latched mode, an event that arrives while the flag is set is dropped. It is not remembered, and the flag stays 0 after a later clear.
- R7: In pulse mode (`latch_mode_i`=0), the flag drops by itself at the edge of the 64th `tick8k_i` pulse seen while it is set.
- R8: A clear strobe with no coinciding event clears the flag at the next edge in either mode, which ends a pulse early.
- R9: When a clear strobe and an event come in the same cycle, the event wins. The flag stays set, and in pulse mode a full 64-tick width starts again.
- R10: `line_n_o` is the inverse of `irq_flag_o` in every cycle.
- R11: In pulse mode, a new event during a pulse restarts the width, so the flag stays set until 64 ticks after the latest event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick8k_i | input | 1 | One-cycle enable at 8192 Hz |
| carry_i | input | 4 | One-cycle carry strobes: bit0 1/64 s, bit1 s, bit2 min, bit3 h |
| period_sel_i | input | 2 | Event source code |
| mask_i | input | 1 | 1 releases the line and blocks events |
| latch_mode_i | input | 1 | 1 latched mode, 0 pulse mode |
| flag_clr_i | input | 1 | One-cycle strobe that clears the flag |
| irq_flag_o | output | 1 | Status flag, 1 while the line is pulled low |
| line_n_o | output | 1 | 0 pulls the line low, 1 releases it |

## Verification
The assertions assume that each carry bit and the clear input are single-cycle strobes sampled on the clock. They also assume the tick enable is a one-cycle pulse that never arrives on two cycles in a row. The stimulus keeps to this: carries and clears are raised for exactly one cycle between falling edges, and the tick comes every fourth cycle from a free-running divider. The period code, mode and mask change only at a falling edge, so every edge sees one stable setting. Mode switches happen only after the flag has been cleared.

// File: rtl/rtc_tick_alarm_pkg.sv
package rtc_tick_alarm_pkg;

    localparam int unsigned SRC_COUNT       = 4;
    localparam int unsigned SRC_SEL_W       = $clog2(SRC_COUNT);
    localparam int unsigned PULSE_TICKS_DEF = 64;

    typedef enum logic [SRC_SEL_W-1:0] {
        SRC_SUB64  = 2'd0,
        SRC_SECOND = 2'd1,
        SRC_MINUTE = 2'd2,
        SRC_HOUR   = 2'd3
    } src_code_e;

    typedef struct packed {
        logic flag;
    } alarm_state_t;

endpackage

// File: rtl/rtc_tick_src_sel.sv
module rtc_tick_src_sel #(
    parameter int unsigned NUM_SRC = 4,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] carry_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               mask_i,
    output logic               event_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = carry_i[g] && (sel_i == SEL_W'(g));
    end

    assign event_o = (|hit) && !mask_i;

endmodule

// File: rtl/rtc_tick_width_timer.sv
module rtc_tick_width_timer #(
    parameter int unsigned PULSE_TICKS = 64,
    localparam int unsigned CNT_W      = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1,
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PULSE_TICKS - 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i && tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d    = '0;
                expire_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm
    import rtc_tick_alarm_pkg::*;
#(
    parameter int unsigned NUM_SRC     = SRC_COUNT,
    parameter int unsigned PULSE_TICKS = PULSE_TICKS_DEF,
    localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick8k_i,
    input  logic [NUM_SRC-1:0] carry_i,
    input  logic [SEL_W-1:0]   period_sel_i,
    input  logic               mask_i,
    input  logic               latch_mode_i,
    input  logic               flag_clr_i,
    output logic               irq_flag_o,
    output logic               line_n_o
);

    alarm_state_t st_d, st_q;
    logic         event_w;
    logic         expire_w;

    rtc_tick_src_sel #(.NUM_SRC(NUM_SRC)) u_src (
        .carry_i (carry_i),
        .sel_i   (period_sel_i),
        .mask_i  (mask_i),
        .event_o (event_w)
    );

    rtc_tick_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_width (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (event_w),
        .run_i     (st_q.flag && !latch_mode_i),
        .tick_i    (tick8k_i),
        .expire_o  (expire_w)
    );

    // Priority: mask, new event, clear strobe, pulse expiry
    always_comb begin
        st_d = st_q;
        if (mask_i)          st_d.flag = 1'b0;
        else if (event_w)    st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
        else if (expire_w)   st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_flag_o = st_q.flag;
    assign line_n_o   = !st_q.flag;

endmodule

module rtc_tick_alarm_chk #(
    parameter int unsigned NUM_SRC     = 4,
    parameter int unsigned PULSE_TICKS = 64,
    localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick8k_i,
    input logic [NUM_SRC-1:0] carry_i,
    input logic [SEL_W-1:0]   period_sel_i,
    input logic               mask_i,
    input logic               latch_mode_i,
    input logic               flag_clr_i,
    input logic               irq_flag_o,
    input logic               line_n_o
);

    logic sel_hit;
    int unsigned ticks_high;

    assign sel_hit = carry_i[period_sel_i];

    always_ff @(posedge clk_i) begin
        if (!rst_ni || (sel_hit && !mask_i) || !irq_flag_o || latch_mode_i)
            ticks_high <= 0;
        else if (tick8k_i)
            ticks_high <= ticks_high + 1;
    end

    assert_mask_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i |=> !irq_flag_o);

    assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mask_i && sel_hit) |=> irq_flag_o);

    assert_latch_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch_mode_i && irq_flag_o && !flag_clr_i && !mask_i) |=> irq_flag_o);

    assert_clear_works_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !mask_i && !sel_hit) |=> !irq_flag_o);

    assert_no_early_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!latch_mode_i && irq_flag_o && !tick8k_i && !flag_clr_i && !mask_i && !sel_hit)
        |=> irq_flag_o);

    assert_width_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_high <= PULSE_TICKS);

    assert_line_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_n_o != irq_flag_o);

endmodule

bind rtc_tick_alarm rtc_tick_alarm_chk #(.NUM_SRC(NUM_SRC), .PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick8k_i     (tick8k_i),
    .carry_i      (carry_i),
    .period_sel_i (period_sel_i),
    .mask_i       (mask_i),
    .latch_mode_i (latch_mode_i),
    .flag_clr_i   (flag_clr_i),
    .irq_flag_o   (irq_flag_o),
    .line_n_o     (line_n_o)
);

// File: tb/rtc_tick_alarm_bench.sv
module rtc_tick_alarm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] carry = '0;
    logic [1:0] sel = '0;
    logic       mask = 1'b0;
    logic       latch = 1'b1;
    logic       clr = 1'b0;
    logic       flag;
    logic       line_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tdiv = 0;
    int m_flag = 0;
    int m_cnt = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    rtc_tick_alarm u_rtc_tick_alarm (
        .clk_i(clk), .rst_ni(rst_n), .tick8k_i(tick), .carry_i(carry),
        .period_sel_i(sel), .mask_i(mask), .latch_mode_i(latch),
        .flag_clr_i(clr), .irq_flag_o(flag), .line_n_o(line_n)
    );

    // tick enable every fourth cycle
    always @(posedge clk) begin
        tdiv <= (tdiv + 1) % 4;
        tick <= (tdiv == 2);
    end

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_cnt = 0;
        end else if (mask) begin
            m_flag = 0;
        end else if (carry[sel]) begin
            m_flag = 1; m_cnt = 0;
        end else if (clr) begin
            m_flag = 0;
        end else if (!latch && m_flag == 1 && tick) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 64) begin m_flag = 0; m_cnt = 0; end
        end
    end

    // every-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (flag !== m_flag[0]) begin
                errors++;
                $display("FAIL %s cycle %0d: flag=%b expected %0d", phase, cyc, flag, m_flag);
            end
            checks++;
            if (line_n !== ~flag) begin
                errors++;
                $display("FAIL R10 cycle %0d: line_n=%b expected %b", cyc, line_n, ~flag);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input int idx, input logic with_clr);
        carry[idx] = 1'b1;
        clr = with_clr;
        @(negedge clk);
        carry = '0;
        clr = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic count_ticks(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            if (!flag) break;
            if (tick) n++;
            @(negedge clk);
        end
    endtask

    int nt;

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        phase = "R1";
        check("R1 flag after reset", flag, 1'b0);
        check("R1 line after reset", line_n, 1'b1);

        // R2 / R3: source selection in latched mode
        latch = 1'b1;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            phase = "R2";
            for (int o = 0; o < 4; o++) begin
                if (o != s) begin
                    strobe(o, 1'b0);
                    check("R2 other carry ignored", flag, 1'b0);
                end
            end
            phase = "R3";
            strobe(s, 1'b0);
            check("R3 selected carry sets flag", flag, 1'b1);
            do_clear();
            check("R8 clear in latched mode", flag, 1'b0);
        end

        // R5: latch holds through ticks
        phase = "R5";
        sel = 2'd1;
        strobe(1, 1'b0);
        wait_cyc(400);
        check("R5 latched flag held", flag, 1'b1);

        // R6: event while set is dropped
        phase = "R6";
        strobe(1, 1'b0);
        wait_cyc(3);
        do_clear();
        wait_cyc(10);
        check("R6 no remembered event", flag, 1'b0);

        // R9 latched: clear and event together
        phase = "R9";
        strobe(1, 1'b0);
        strobe(1, 1'b1);
        check("R9 event beats clear (latched)", flag, 1'b1);
        do_clear();

        // R4: mask
        phase = "R4";
        strobe(2, 1'b0);
        sel = 2'd2;
        strobe(2, 1'b0);
        check("R4 set before mask", flag, 1'b1);
        mask = 1'b1;
        wait_cyc(1);
        check("R4 mask releases", flag, 1'b0);
        strobe(2, 1'b0);
        check("R4 masked event ignored", flag, 1'b0);
        mask = 1'b0;
        wait_cyc(5);
        check("R4 nothing after unmask", flag, 1'b0);

        // R7: pulse width
        phase = "R7";
        latch = 1'b0;
        sel = 2'd0;
        strobe(0, 1'b0);
        count_ticks(nt);
        check_int("R7 pulse width in ticks", nt, 64);
        check("R7 released after pulse", flag, 1'b0);

        // R8: early end
        phase = "R8";
        sel = 2'd3;
        strobe(3, 1'b0);
        wait_cyc(20);
        do_clear();
        check("R8 pulse ended early", flag, 1'b0);

        // R9 pulse mode: restart on clear+event
        phase = "R9";
        strobe(3, 1'b0);
        wait_cyc(40);
        strobe(3, 1'b1);
        count_ticks(nt);
        check_int("R9 full width after clear+event", nt, 64);

        // R11: retrigger during pulse
        phase = "R11";
        sel = 2'd1;
        strobe(1, 1'b0);
        wait_cyc(100);
        strobe(1, 1'b0);
        count_ticks(nt);
        check_int("R11 width restarted", nt, 64);

        wait_cyc(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule